// File: doc/BRIEF.md
# Codec reset and power-down sequencer

This block sits in the digital core of an audio codec and decides when the serial link's bit clock may run. It handles three kinds of reset. A cold reset on the active-low reset pin clears all state. A write to register index 00h clears only the register contents. A warm reset is a long high pulse on the frame-sync line while the link is powered down. It restarts the bit clock and leaves every register value as it was.

The block holds the power-down control byte. Bits 0 to 3 switch off the ADC, DAC, mixer and reference, and bit 4 stops the link. It drives the analog enables and reports a ready flag for each analog section. When the link power-down bit is written, the bit clock stops at the end of the command slot of a later frame. At the first clock edge after reset release, the block latches the codec ID from the inverted strap pins. At the same edge it picks a test mode from the levels of the outbound data and sync lines, and that mode lasts until the next cold reset.

Top module: `codec_pwr_seq`

## Requirements
- R1: While `rst_n` is low, the outputs take these values: `reg_rst`=1, `pd_ctrl`=0, `pwr_en`=4'b1111, `pd_status`=0, `codec_id`=0, `bclk_en`=0, `bclk_oe`=0, `sdi_oe`=0, `ate_mode`=0 and `vendor_mode`=0.
- R2: The first rising clock edge with `rst_n` high latches `codec_id` = ~`id_strap_n`. The value then holds until the next cold reset, whatever the straps do.
- R3: After a cold reset, `bclk_en` rises just after the RESTART_DLY-th clock edge, counting the first edge with `rst_n` high as edge 1.
- R4: `sdi_oe` is 1 from that first edge onward. `bclk_oe` is 1 only when, in addition, `codec_id` is 2'b00. An ID of 00 drives the bit clock, and any other ID receives it. In-circuit test mode overrides both.
- R5: If `sdo_in` is 1 at the first edge, `ate_mode` is set. `bclk_oe`, `sdi_oe` and `bclk_en` then stay 0. This mode takes priority over the vendor mode.
- R6: If `sync_in` is 1 and `sdo_in` is 0 at the first edge, `vendor_mode` is set. The link otherwise behaves normally.
- R7: A `pd_wr` with `pd_wdata[4]`=1 arms a link shutdown. `bclk_en` falls after the first edge that has `slot2_end` high while the link runs. A `slot2_end` in the same cycle as the write does not count. A write with bit 4 = 0 disarms a pending shutdown.
- R8: Suppose the link is down and no test mode is active. If `sync_in` is sampled high on at least SYNC_MIN consecutive edges and then sampled low at edge W, `bclk_en` rises just after edge W+RESTART_DLY. `pd_ctrl` keeps its value.
- R9: These `sync_in` pulses have no effect on `bclk_en`: a pulse shorter than SYNC_MIN edges, a pulse while the link runs, and any pulse while a test mode is active.
- R10: `reg00_wr` clears `pd_ctrl` and any pending shutdown, and gives a one-cycle `reg_rst` pulse after the edge. The link state and `codec_id` are unchanged.
- R11: `pwr_en` is {!PR3, !(PR2|PR3), !PR1, !PR0}, where PRn is `pd_ctrl[n]`. Bit i of `pd_status` is 0 while section i is off. It rises RDY_DLY edges after the edge that switches the section on.
- R12: `pd_wr` loads `pd_ctrl` with `pd_wdata`. A `reg00_wr` in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Cold reset pin, active low, asynchronous |
| sync_in | input | 1 | Frame-sync line level |
| sdo_in | input | 1 | Outbound serial data line level |
| id_strap_n | input | 2 | Inverted codec ID straps |
| slot2_end | input | 1 | Pulse at the end of the frame's command slot |
| reg00_wr | input | 1 | Write to register index 00h |
| pd_wr | input | 1 | Write to the power-down control byte |
| pd_wdata | input | 8 | Power-down control write data |
| reg_rst | output | 1 | Register-file reset |
| pd_ctrl | output | 8 | Power-down control byte readback |
| pwr_en | output | 4 | Enables for reference, mixer, DAC, ADC |
| pd_status | output | 4 | Ready flags for reference, mixer, DAC, ADC |
| codec_id | output | 2 | Latched codec ID |
| bclk_en | output | 1 | Bit clock (and inbound data) running |
| bclk_oe | output | 1 | Bit clock pin driven by this codec |
| sdi_oe | output | 1 | Inbound data pin driven |
| ate_mode | output | 1 | In-circuit test mode active |
| vendor_mode | output | 1 | Vendor test mode active |

## Verification
The hardest state to reach is a powered-down link that must wake through the sync line. The stimulus first writes the shutdown bit. It places one slot-end pulse in the same cycle as that write, which must not stop the clock, and a second slot-end pulse later, which must. It then sends a sync pulse one edge too short, followed by one long enough. The two test modes are reached by holding the outbound data line or the sync line high across a cold-reset release. A second shutdown then confirms that the wake path is locked out in those modes. A cycle-level reference model is compared against every output on every clock.

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq #(
  parameter int RESTART_DLY = 4,
  parameter int SYNC_MIN    = 8,
  parameter int RDY_DLY     = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_in,
  input  logic       sdo_in,
  input  logic [1:0] id_strap_n,
  input  logic       slot2_end,
  input  logic       reg00_wr,
  input  logic       pd_wr,
  input  logic [7:0] pd_wdata,
  output logic       reg_rst,
  output logic [7:0] pd_ctrl,
  output logic [3:0] pwr_en,
  output logic [3:0] pd_status,
  output logic [1:0] codec_id,
  output logic       bclk_en,
  output logic       bclk_oe,
  output logic       sdi_oe,
  output logic       ate_mode,
  output logic       vendor_mode
);
  localparam int WCW = $clog2(RESTART_DLY + 1);
  localparam int SCW = $clog2(SYNC_MIN + 1);
  localparam int RCW = $clog2(RDY_DLY + 1);

  typedef enum logic [1:0] {L_WAKE, L_RUN, L_DOWN} link_t;

  link_t          link_q;
  logic           started_q, regclr_q, down_pend_q;
  logic [WCW-1:0] wake_cnt_q;
  logic [SCW-1:0] sync_cnt_q;
  logic [3:0]     pd_off;
  logic           test_mode, shut_now, warm_done;

  assign test_mode = ate_mode | vendor_mode;
  assign shut_now  = (link_q == L_RUN) && slot2_end && down_pend_q;
  assign warm_done = (link_q == L_DOWN) && !test_mode && !sync_in &&
                     (sync_cnt_q == SCW'(SYNC_MIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q   <= 1'b0;
      codec_id    <= 2'b00;
      ate_mode    <= 1'b0;
      vendor_mode <= 1'b0;
    end else if (!started_q) begin
      started_q   <= 1'b1;
      codec_id    <= ~id_strap_n;
      ate_mode    <= sdo_in;
      vendor_mode <= sync_in & ~sdo_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q     <= L_WAKE;
      wake_cnt_q <= '0;
      sync_cnt_q <= '0;
    end else begin
      case (link_q)
        L_WAKE:
          if (wake_cnt_q == WCW'(RESTART_DLY - 1)) begin
            link_q     <= L_RUN;
            wake_cnt_q <= '0;
          end else begin
            wake_cnt_q <= wake_cnt_q + 1'b1;
          end
        L_RUN:
          if (shut_now) link_q <= L_DOWN;
        L_DOWN:
          if (warm_done) begin
            link_q     <= L_WAKE;
            sync_cnt_q <= '0;
          end else if (test_mode || !sync_in) begin
            sync_cnt_q <= '0;
          end else if (sync_cnt_q != SCW'(SYNC_MIN)) begin
            sync_cnt_q <= sync_cnt_q + 1'b1;
          end
        default: link_q <= L_WAKE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_ctrl     <= 8'h00;
      down_pend_q <= 1'b0;
      regclr_q    <= 1'b0;
    end else begin
      regclr_q <= reg00_wr;
      if (reg00_wr) begin
        pd_ctrl     <= 8'h00;
        down_pend_q <= 1'b0;
      end else if (pd_wr) begin
        pd_ctrl     <= pd_wdata;
        down_pend_q <= pd_wdata[4];
      end else if (shut_now) begin
        down_pend_q <= 1'b0;
      end
    end
  end

  assign pd_off = {pd_ctrl[3], pd_ctrl[2] | pd_ctrl[3], pd_ctrl[1], pd_ctrl[0]};
  assign pwr_en = ~pd_off;

  for (genvar g = 0; g < 4; g++) begin : g_rdy
    logic [RCW-1:0] cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt_q <= '0;
      else if (pd_off[g])                 cnt_q <= '0;
      else if (cnt_q != RCW'(RDY_DLY))    cnt_q <= cnt_q + 1'b1;
    end
    assign pd_status[g] = (cnt_q == RCW'(RDY_DLY)) && !pd_off[g];
  end

  assign reg_rst = !rst_n | regclr_q;
  assign bclk_en = (link_q == L_RUN) && !ate_mode;
  assign bclk_oe = started_q && !ate_mode && (codec_id == 2'b00);
  assign sdi_oe  = started_q && !ate_mode;
endmodule

// File: rtl/codec_pwr_seq_chk.sv
module codec_pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_in,
  input logic       sdo_in,
  input logic [1:0] id_strap_n,
  input logic       slot2_end,
  input logic       reg00_wr,
  input logic       pd_wr,
  input logic [7:0] pd_wdata,
  input logic       reg_rst,
  input logic [7:0] pd_ctrl,
  input logic [3:0] pwr_en,
  input logic [3:0] pd_status,
  input logic [1:0] codec_id,
  input logic       bclk_en,
  input logic       bclk_oe,
  input logic       sdi_oe,
  input logic       ate_mode,
  input logic       vendor_mode
);
  AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sdi_oe && $past(sdi_oe)) |-> $stable(codec_id)); // R2
  AST_ATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ate_mode |-> (!bclk_oe && !sdi_oe && !bclk_en)); // R5
  AST_MODES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ate_mode && vendor_mode)); // R6
  AST_STOP_AT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bclk_en) && !ate_mode) |-> $past(slot2_end)); // R7
  AST_REGRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg00_wr |=> (reg_rst && pd_ctrl == 8'h00)); // R10
  AST_READY_AFTER_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_status[0]) |-> $past(!pd_ctrl[0])); // R11
  AST_VREF_MIXER: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en[3] |-> !pwr_en[2]); // R11
  AST_PD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_wr && !reg00_wr) |=> (pd_ctrl == $past(pd_wdata))); // R12
endmodule

bind codec_pwr_seq codec_pwr_seq_chk u_chk (.*);

// File: tb/codec_pwr_seq_tb.sv
`timescale 1ns/1ps
module codec_pwr_seq_tb;
  localparam int D = 4, SMIN = 8, RDY = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0, sync_in = 1'b0, sdo_in = 1'b0, slot2_end = 1'b0;
  logic reg00_wr = 1'b0, pd_wr = 1'b0;
  logic [1:0] id_strap_n = 2'b10;
  logic [7:0] pd_wdata = 8'h00;
  logic reg_rst, bclk_en, bclk_oe, sdi_oe, ate_mode, vendor_mode;
  logic [7:0] pd_ctrl;
  logic [3:0] pwr_en, pd_status;
  logic [1:0] codec_id;

  always #2 clk = ~clk;

  codec_pwr_seq #(.RESTART_DLY(D), .SYNC_MIN(SMIN), .RDY_DLY(RDY)) u_dut (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_started, m_ate, m_vend, m_id, m_pd, m_link, m_wake, m_sync, m_pend, m_regclr;
  int m_rc[4];

  function automatic int m_off(int i);
    case (i)
      0: return (m_pd >> 0) & 1;
      1: return (m_pd >> 1) & 1;
      2: return ((m_pd >> 2) | (m_pd >> 3)) & 1;
      default: return (m_pd >> 3) & 1;
    endcase
  endfunction

  task automatic m_reset();
    m_started = 0; m_ate = 0; m_vend = 0; m_id = 0; m_pd = 0;
    m_link = 0; m_wake = 0; m_sync = 0; m_pend = 0; m_regclr = 0;
    for (int i = 0; i < 4; i++) m_rc[i] = 0;
  endtask

  task automatic m_step();
    int shut;
    for (int i = 0; i < 4; i++) begin
      if (m_off(i) != 0) m_rc[i] = 0;
      else if (m_rc[i] < RDY) m_rc[i]++;
    end
    shut = (m_link == 1 && slot2_end && m_pend != 0);
    if (m_started == 0) begin
      m_started = 1; m_id = 3 - id_strap_n;
      m_ate = sdo_in; m_vend = sync_in && !sdo_in;
    end
    if (m_link == 0) begin
      if (m_wake == D - 1) begin m_link = 1; m_wake = 0; end
      else m_wake++;
    end else if (m_link == 1) begin
      if (shut) m_link = 2;
    end else begin
      if (m_ate == 0 && m_vend == 0 && !sync_in && m_sync == SMIN) begin
        m_link = 0; m_sync = 0;
      end else if (m_ate != 0 || m_vend != 0 || !sync_in) m_sync = 0;
      else if (m_sync < SMIN) m_sync++;
    end
    if (reg00_wr) begin m_pd = 0; m_pend = 0; end
    else if (pd_wr) begin m_pd = pd_wdata; m_pend = pd_wdata[4]; end
    else if (shut) m_pend = 0;
    m_regclr = reg00_wr;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else m_step();
  end

  always @(negedge clk) begin
    int st;
    cyc++;
    if (!rst_n) m_reset();
    st = 0;
    for (int i = 0; i < 4; i++)
      if (m_rc[i] == RDY && m_off(i) == 0) st |= (1 << i);
    chk("R1 R10 reg_rst", reg_rst, (!rst_n || m_regclr != 0));
    chk("R12 R10 pd_ctrl", pd_ctrl, m_pd);
    chk("R11 pwr_en", pwr_en, (m_off(0) ? 0 : 1) | (m_off(1) ? 0 : 2) |
                              (m_off(2) ? 0 : 4) | (m_off(3) ? 0 : 8));
    chk("R11 pd_status", pd_status, st);
    chk("R2 codec_id", codec_id, m_id);
    chk("R3 R7 R8 R9 bclk_en", bclk_en, (m_link == 1 && m_ate == 0));
    chk("R4 bclk_oe", bclk_oe, (m_started != 0 && m_ate == 0 && m_id == 0));
    chk("R4 sdi_oe", sdi_oe, (m_started != 0 && m_ate == 0));
    chk("R5 ate_mode", ate_mode, m_ate);
    chk("R6 vendor_mode", vendor_mode, m_vend);
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic pd_write(input logic [7:0] v);
    pd_wr = 1'b1; pd_wdata = v; tick(1); pd_wr = 1'b0;
  endtask

  task automatic sync_pulse(input int n);
    sync_in = 1'b1; tick(n); sync_in = 1'b0; tick(1);
  endtask

  task automatic cold(input logic [1:0] straps, input logic sdo, input logic syn);
    rst_n = 1'b0; sync_in = syn; sdo_in = sdo; id_strap_n = straps;
    tick(3);
    rst_n = 1'b1; tick(1);
    sync_in = 1'b0; sdo_in = 1'b0;
  endtask

  task automatic shutdown();
    pd_wr = 1'b1; pd_wdata = 8'h10; slot2_end = 1'b1; tick(1);
    pd_wr = 1'b0; slot2_end = 1'b0; tick(2);
    slot2_end = 1'b1; tick(1); slot2_end = 1'b0; tick(2);
  endtask

  initial begin
    tick(3);                       // R1 reset values
    rst_n = 1'b1; tick(1);         // R2 R3 release, id 01
    tick(12);
    id_strap_n = 2'b01; tick(3);   // R2 hold
    pd_write(8'h01); tick(3);      // R11 ADC off
    pd_write(8'h08); tick(2);      // R11 vref off takes mixer
    pd_write(8'h06); tick(2);
    pd_write(8'h00); tick(RDY + 3);
    sync_pulse(10); tick(2);       // R9 sync while running
    shutdown(); tick(3);           // R7
    pd_write(8'h00); tick(2);
    sync_pulse(SMIN - 1); tick(4); // R9 short pulse
    sync_pulse(SMIN + 2); tick(D + 3); // R8 warm wake
    pd_write(8'h10); pd_write(8'h00);  // R7 disarm
    slot2_end = 1'b1; tick(1); slot2_end = 1'b0; tick(3);
    pd_wr = 1'b1; pd_wdata = 8'h1F; reg00_wr = 1'b1; tick(1); // R10 R12
    pd_wr = 1'b0; reg00_wr = 1'b0;
    slot2_end = 1'b1; tick(1); slot2_end = 1'b0; tick(RDY + 2);
    cold(2'b11, 1'b1, 1'b1); tick(D + 2);   // R5 ATE wins
    shutdown(); sync_pulse(SMIN + 2); tick(D + 2);
    cold(2'b11, 1'b0, 1'b1); tick(D + 2);   // R6 vendor mode
    shutdown(); sync_pulse(SMIN + 2); tick(D + 2); // R9 warm ignored
    cold(2'b11, 1'b0, 1'b0); tick(D + 4);   // R4 primary drives clock
    shutdown(); sync_pulse(SMIN); tick(D + 3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule